// File: doc/BRIEF.md
# Composite-Field Byte Substitution and Column Mix

This block turns one 32-bit word into another in a single pass. It cuts the word into four byte lanes, with lane 0 in bits 7:0 and lane 3 in bits 31:24. Each lane goes through the well-known AES-style substitution: a multiplicative inverse in GF(2^8) followed by an affine map. The four substituted bytes are then combined by a circulant column-mixing matrix. The block fits into the nonlinear stage of a word-oriented keystream generator. There, several copies of it run side by side on every keystream step.

The byte inverse is not computed in GF(2^8). Each byte is first mapped by an 8x8 bit matrix into the tower field GF((2^4)^2). The inverse is formed there from nibble multiplies, a nibble square, a scaling by a constant and a 16-entry nibble inverse. A second bit matrix maps the result back. The affine step and the column mix stay in the ordinary byte field.

The parameter `RegOut` selects how results leave the block. With `RegOut` = 0 the result appears in the same cycle and the valid flag passes straight through. With `RegOut` = 1 each accepted word is captured in a one-stage register.

Top module: `subw_xform`

## Requirements
- R1: Each lane replaces byte a by S(a). S(a) is inv(a) passed through the affine map with constant 0x63, where inv is the inverse modulo x^8+x^4+x^3+x+1 and inv(0x00)=0x00. Examples: a word of all 0x00 gives 0x63636363, all 0x01 gives 0x7C7C7C7C, and all 0x53 gives 0xEDEDEDED.
- R2: Let s0..s3 be the substituted lanes 0..3. The result lane d0 equals 2·s0 ⊕ 3·s1 ⊕ s2 ⊕ s3, and d1, d2, d3 follow by rotating the coefficients one lane each time. Multiplication is in GF(2^8) modulo 0x11B, and lane k sits in bits 8k+7:8k of both words.
- R3: The tower-field inversion path matches the direct GF(2^8) inverse for all 256 byte values. A word that repeats one byte b in all four lanes therefore yields {S(b),S(b),S(b),S(b)}.
- R4: With RegOut=0, outWord equals the transform of inWord and outValid equals inValid within the same cycle, with no clock involved.
- R5: With RegOut=1, a word presented with inValid high appears on outWord after the next rising clock edge, and outValid is inValid delayed by one cycle.
- R6: With RegOut=1, inWord is ignored while inValid is low: outWord keeps its last captured value.
- R7: With RegOut=1, an active-low reset clears outValid and outWord to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | The input word is meaningful this cycle |
| inWord | input | 32 | Input word, lane 0 in bits 7:0 |
| outValid | output | 1 | The output word is meaningful |
| outWord | output | 32 | Substituted and mixed word |

## Verification
The bench builds two copies side by side, one with RegOut=1 and one with RegOut=0, and drives both from the same inputs. The combinational copy exposes the transform within the same cycle. Sweeping all 256 repeated-byte words through it covers every entry of the tower-field inversion against a direct GF(2^8) reference. The registered copy brings into reach the reset clear, the one-cycle latency of data and valid, and the holding of the last result while inputs are invalid. Random words add coverage of mixed lane values and of the lane order of the column mix.

// File: rtl/subw_pkg.sv
package subw_pkg;

  localparam int ByteW = 8;
  localparam int NibW  = ByteW / 2;
  localparam int Lanes = 4;
  localparam int WordW = ByteW * Lanes;

  typedef logic [ByteW-1:0] byte_t;
  typedef logic [NibW-1:0]  nib_t;
  typedef logic [WordW-1:0] word_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;

  // bit matrices, row for output bit 7 in the top byte, leftmost column = input bit 7
  localparam logic [ByteW*ByteW-1:0] ToTower = {
    8'b10100000, 8'b10101100, 8'b11010010, 8'b01110000,
    8'b11000110, 8'b01010010, 8'b00001010, 8'b11011101};
  localparam logic [ByteW*ByteW-1:0] FromTower = {
    8'b00100100, 8'b11101110, 8'b10100100, 8'b01011010,
    8'b10110010, 8'b01110010, 8'b10110000, 8'b01010001};
  localparam logic [ByteW*ByteW-1:0] AffineRows = {
    8'b11111000, 8'b01111100, 8'b00111110, 8'b00011111,
    8'b10001111, 8'b11000111, 8'b11100011, 8'b11110001};
  localparam byte_t AffineConst = 8'h63;

  // nibble field modulus x^4+x+1 (low terms), quadratic constant w^14
  localparam nib_t NibPolyLow = 4'h3;
  localparam nib_t TowerConst = 4'h9;
  localparam byte_t BytePolyLow = 8'h1B;

  function automatic byte_t matVec(input logic [ByteW*ByteW-1:0] rows, input byte_t v);
    byte_t r;
    for (int k = 0; k < ByteW; k++) r[k] = ^(rows[k*ByteW +: ByteW] & v);
    return r;
  endfunction

  function automatic nib_t nibMul(input nib_t a, input nib_t b);
    nib_t acc;
    nib_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < NibW; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[NibW-2:0], 1'b0} ^ (sh[NibW-1] ? NibPolyLow : '0);
    end
    return acc;
  endfunction

  function automatic nib_t nibSquare(input nib_t a);
    return nibMul(a, a);
  endfunction

  function automatic nib_t nibScale(input nib_t a);
    return nibMul(a, TowerConst);
  endfunction

  function automatic nib_t nibInv(input nib_t a);
    nib_t r;
    case (a)
      4'h0: r = 4'h0;  4'h1: r = 4'h1;  4'h2: r = 4'h9;  4'h3: r = 4'hE;
      4'h4: r = 4'hD;  4'h5: r = 4'hB;  4'h6: r = 4'h7;  4'h7: r = 4'h6;
      4'h8: r = 4'hF;  4'h9: r = 4'h2;  4'hA: r = 4'hC;  4'hB: r = 4'h5;
      4'hC: r = 4'hA;  4'hD: r = 4'h4;  4'hE: r = 4'h3;  default: r = 4'h8;
    endcase
    return r;
  endfunction

  function automatic byte_t xtime(input byte_t b);
    return {b[ByteW-2:0], 1'b0} ^ (b[ByteW-1] ? BytePolyLow : '0);
  endfunction

endpackage

// File: rtl/subw_byte_sub.sv
module subw_byte_sub
  import subw_pkg::*;
(
  input  byte_t inByte,
  output byte_t outByte
);

  byte_t mapped;
  nib_t  hiNib, loNib, sumNib, delta, deltaInv, invHi, invLo;
  byte_t invByte;

  always_comb begin
    mapped   = matVec(ToTower, inByte);
    hiNib    = mapped[ByteW-1:NibW];
    loNib    = mapped[NibW-1:0];
    sumNib   = hiNib ^ loNib;
    // norm of the element: w14*hi^2 + lo*(hi+lo)
    delta    = nibScale(nibSquare(hiNib)) ^ nibMul(loNib, sumNib);
    deltaInv = nibInv(delta);
    invHi    = nibMul(hiNib, deltaInv);
    invLo    = nibMul(sumNib, deltaInv);
    invByte  = matVec(FromTower, {invHi, invLo});
    outByte  = matVec(AffineRows, invByte) ^ AffineConst;
  end

endmodule

// File: rtl/subw_datapath.sv
module subw_datapath
  import subw_pkg::*;
#(
  parameter bit RegOut = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  word_t       inWord,
  input  ctrlStrobe_t strobe,
  output word_t       outWord
);

  byte_t subBytes [Lanes];
  byte_t mixBytes [Lanes];
  word_t mixedWord;

  for (genvar g = 0; g < Lanes; g++) begin : gLane
    subw_byte_sub u_sub (
      .inByte (inWord[g*ByteW +: ByteW]),
      .outByte(subBytes[g])
    );

    always_comb begin
      mixBytes[g] = xtime(subBytes[g])
                  ^ xtime(subBytes[(g+1) % Lanes]) ^ subBytes[(g+1) % Lanes]
                  ^ subBytes[(g+2) % Lanes]
                  ^ subBytes[(g+3) % Lanes];
    end

    assign mixedWord[g*ByteW +: ByteW] = mixBytes[g];
  end

  if (RegOut) begin : gReg
    word_t wordQ;
    always_ff @(posedge clk) begin
      if (!rstN)               wordQ <= '0;
      else if (strobe.capture) wordQ <= mixedWord;
    end
    assign outWord = wordQ;
  end else begin : gComb
    assign outWord = mixedWord;
  end

endmodule

// File: rtl/subw_control.sv
module subw_control
  import subw_pkg::*;
#(
  parameter bit RegOut = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  assign strobe.capture = inValid;

  if (RegOut) begin : gReg
    logic validQ;
    always_ff @(posedge clk) begin
      if (!rstN) validQ <= 1'b0;
      else       validQ <= inValid;
    end
    assign outValid = validQ;
  end else begin : gComb
    assign outValid = inValid;
  end

endmodule

// File: rtl/subw_xform.sv
module subw_xform
  import subw_pkg::*;
#(
  parameter bit RegOut = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WordW-1:0]  inWord,
  output logic              outValid,
  output logic [WordW-1:0]  outWord
);

  ctrlStrobe_t strobe;

  subw_control #(.RegOut(RegOut)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  subw_datapath #(.RegOut(RegOut)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .inWord (inWord),
    .strobe (strobe),
    .outWord(outWord)
  );

endmodule

// File: rtl/subw_xform_chk.sv
module subw_xform_chk
  import subw_pkg::*;
#(
  parameter bit RegOut = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [WordW-1:0] inWord,
  input logic             outValid,
  input logic [WordW-1:0] outWord
);

  if (RegOut) begin : gReg
    // R5: valid is delayed by exactly one cycle
    a_r5_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> outValid == $past(inValid));
    // R5: an accepted word raises valid next cycle
    a_r5_capture: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);
    // R6: no capture while input invalid
    a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> $stable(outWord));
    // R1: zero word maps to repeated affine constant
    a_r1_zero_word: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inWord == '0) |=> outWord == {Lanes{AffineConst}});
  end else begin : gComb
    // R4: same-cycle valid
    a_r4_valid_pass: assert property (@(posedge clk) disable iff (!rstN)
      outValid == inValid);
    // R1: zero word maps to repeated affine constant
    a_r1_zero_word: assert property (@(posedge clk) disable iff (!rstN)
      inWord == '0 |-> outWord == {Lanes{AffineConst}});
    // R3: repeated 0x01 lanes give repeated 0x7C
    a_r3_one_word: assert property (@(posedge clk) disable iff (!rstN)
      inWord == {Lanes{8'h01}} |-> outWord == {Lanes{8'h7C}});
  end

endmodule

bind subw_xform subw_xform_chk #(.RegOut(RegOut)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inWord  (inWord),
  .outValid(outValid),
  .outWord (outWord)
);

// File: tb/test_subw_xform.sv
module test_subw_xform;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        regValid, combValid;
  logic [31:0] regWord, combWord;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  subw_xform #(.RegOut(1'b1)) i_subw_xform (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(regValid), .outWord(regWord));

  subw_xform #(.RegOut(1'b0)) i_subw_xform_comb (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(combValid), .outWord(combWord));

  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] sh = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] refInv(input logic [7:0] a);
    for (int x = 1; x < 256; x++)
      if (refMul(a, 8'(x)) == 8'h01) return 8'(x);
    return 8'h00;
  endfunction

  function automatic logic [7:0] refSbox(input logic [7:0] a);
    logic [7:0] v = refInv(a);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8];
    return r ^ 8'h63;
  endfunction

  function automatic logic [31:0] refWord(input logic [31:0] w);
    logic [7:0] s [4];
    logic [31:0] r;
    for (int i = 0; i < 4; i++) s[i] = refSbox(w[i*8 +: 8]);
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = refMul(s[i], 8'h02) ^ refMul(s[(i+1)%4], 8'h03)
                  ^ s[(i+2)%4] ^ s[(i+3)%4];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  logic [31:0] regExp = '0;

  // drive at falling edge, check comb copy, then registered copy one edge later
  task automatic apply(input logic v, input logic [31:0] w, input string tag);
    logic [31:0] e = refWord(w);
    @(negedge clk);
    inValid = v;
    inWord  = w;
    #1;
    check({tag, " R4 comb word"}, combWord, e);
    check("R4 comb valid", {31'b0, combValid}, {31'b0, v});
    @(negedge clk);
    if (v) regExp = e;
    check(v ? "R5 reg word" : "R6 reg hold", regWord, regExp);
    check("R5 reg valid", {31'b0, regValid}, {31'b0, v});
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R7 reset clears registered outputs
    check("R7 reset word", regWord, 32'h0);
    check("R7 reset valid", {31'b0, regValid}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 directed values
    apply(1'b1, 32'h00000000, "R1 zero");
    apply(1'b1, 32'h01010101, "R1 one");
    check("R1 one literal", regWord, 32'h7C7C7C7C);
    apply(1'b1, 32'h53535353, "R1 53");
    check("R1 53 literal", regWord, 32'hEDEDEDED);

    // R2 single active lane in each position
    for (int k = 0; k < 4; k++) apply(1'b1, 32'h01 << (8*k), "R2 lane");

    // R6 invalid input ignored
    apply(1'b0, 32'hDEADBEEF, "R6 idle");
    apply(1'b0, 32'h12345678, "R6 idle");

    // R3 full byte sweep through the comb copy
    for (int b = 0; b < 256; b++) begin
      @(negedge clk);
      inValid = 1'b1;
      inWord  = {4{8'(b)}};
      #1;
      check("R3 sweep", combWord, {4{refSbox(8'(b))}});
    end
    @(negedge clk);
    regExp = refWord({4{8'hFF}});
    check("R5 last sweep word", regWord, regExp);

    // R2 random words, random valid pattern
    for (int n = 0; n < 300; n++) begin
      logic [31:0] w = $urandom();
      logic v = ($urandom() % 4) != 0;
      apply(v, w, "R2 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule